// File: doc/BRIEF.md
# Guarded System Clock Mode Controller

This block produces the internal system clock enable of a small controller from two oscillators. One is a fast main oscillator. The other is a 32 kHz sub-oscillator. Both oscillators are modelled as single-cycle enable ticks in the reference clock domain `clk`. A 4-bit mode register sets four things: the clock source, the divide ratio of the main clock, whether the main oscillator is halted, and whether the sub-oscillator runs. Software writes this register through a write port. A write is accepted only when it follows one edge of a fixed graph of permitted mode changes. A rejected write leaves the register unchanged and raises a one-cycle flag.

A power sequencer adds wait and stop modes. In wait mode the system clock enable is held off, but the oscillators and the timer/display enable keep running. In stop mode every oscillator enable and the timer/display enable are off. When the block is woken from wait, it resumes at once. When it is woken from stop, it first counts a fixed number of ticks of the oscillator that drives the system clock, and only then releases the clock. Either way the block returns to the mode it had before. After the main oscillator is restarted, a stabilisation counter stops the clock source from being switched back to it too early.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 4'b0100 (middle speed, main oscillator running, sub-oscillator off). In the same state `main_osc_en`=1, `sub_osc_en`=0, `periph_en`=1, `illegal_write`=0 and `sys_tick`=0.
- R2: The mode bits mean the following. Bit 3 selects the source: 0 = main, 1 = sub. Bit 2 selects the main divide: 0 = fast, 1 = slow. Bit 1 halts the main oscillator when 1. Bit 0 runs the sub-oscillator when 1. While the block is running, `main_osc_en` = !mode[1] and `sub_osc_en` = mode[0].
- R3: While running, `sys_tick` pulses once for every MAIN_DIV_FAST (bit 3=0, bit 2=0), MAIN_DIV_SLOW (bit 3=0, bit 2=1) or SUB_DIV (bit 3=1) ticks of the selected source. Ticks of the other oscillator are ignored, and so are ticks of an oscillator whose enable is off.
- R4: A write that changes only bit 2, or that changes no bit, is always accepted.
- R5: Bit 0 may change only while bit 3 is 0. Bit 3 may change only while bit 0 is 1 and bit 1 is 0. Bit 1 may change only while bit 3 is 1.
- R6: A write is rejected if it breaks R5 or changes more than one of bits 3, 1 and 0. On rejection `mode` keeps its value and `illegal_write` is 1 for exactly the one cycle after the write.
- R7: An accepted write that clears bit 1 starts a count of MAIN_STAB main oscillator ticks. Until that count expires, a write that clears bit 3 is rejected as in R6.
- R8: While running, `stop_req` enters stop mode, and it wins over `wait_req`. In stop mode `main_osc_en`, `sub_osc_en`, `periph_en` and `sys_tick` are all 0, and `mode` is kept.
- R9: While running, `wait_req` enters wait mode. In wait mode `sys_tick` is 0 and `periph_en` is 1. `wake` returns the block to running with `mode` unchanged.
- R10: After `wake` in stop mode, the first `sys_tick` comes after STOP_DELAY + (divide ratio) ticks of the selected source. Ticks of the other oscillator do not shorten this delay.
- R11: A write made while the block is not running has no effect: `mode` stays unchanged and `illegal_write` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 4 | Proposed mode value |
| main_tick | input | 1 | Main oscillator tick |
| sub_tick | input | 1 | Sub-oscillator tick |
| stop_req | input | 1 | Request stop mode |
| wait_req | input | 1 | Request wait mode |
| wake | input | 1 | Release wait or stop |
| mode | output | 4 | Current mode register |
| illegal_write | output | 1 | One-cycle pulse on a rejected write |
| sys_tick | output | 1 | Divided system clock enable |
| main_osc_en | output | 1 | Main oscillator run enable |
| sub_osc_en | output | 1 | Sub-oscillator run enable |
| periph_en | output | 1 | Timer/display keep-running enable |

## Verification
On every cycle the assertions check these properties:
- the mode register never reaches a combination that the transition graph cannot produce;
- a register change always follows a write made while running, and changes at most one guarded bit;
- a rejected write leaves the register stable;
- a system tick appears only after a cycle in the running state;
- the source select bit cannot fall while main oscillator stabilisation is pending.

The scenarios show the rest: the exact divide ratio of each mode, the length of the delay after stop release, and the fact that the other oscillator's ticks do not shorten that delay. They also show that writes during stop are ignored and that stop wins over wait.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

   typedef enum logic [1:0] {
      PS_RUN    = 2'd0,
      PS_WAIT   = 2'd1,
      PS_STOP   = 2'd2,
      PS_SETTLE = 2'd3
   } pwr_state_t;

   localparam int unsigned MB_SUB_ON = 0;
   localparam int unsigned MB_MAIN_HALT = 1;
   localparam int unsigned MB_DIV_SLOW = 2;
   localparam int unsigned MB_SRC_SUB = 3;

   localparam logic [3:0] MODE_AT_RESET = 4'b0100;
   localparam logic [3:0] GUARDED_BITS = 4'b1011;

   // Legality of one proposed step on the mode graph.
   function automatic logic step_allowed(input logic [3:0] cur,
                                         input logic [3:0] nxt,
                                         input logic       stab_pending);
      logic [3:0] d;
      int         n;
      d = (cur ^ nxt) & GUARDED_BITS;
      n = int'(d[MB_SUB_ON]) + int'(d[MB_MAIN_HALT]) + int'(d[MB_SRC_SUB]);
      if (n == 0) return 1'b1;
      if (n > 1) return 1'b0;
      if (d[MB_SUB_ON]) return !cur[MB_SRC_SUB];
      if (d[MB_MAIN_HALT]) return cur[MB_SRC_SUB];
      return cur[MB_SUB_ON] && !cur[MB_MAIN_HALT] &&
             (nxt[MB_SRC_SUB] || !stab_pending);
   endfunction

endpackage

// File: rtl/sysclk_mode_guard.sv
module sysclk_mode_guard
   import sysclk_pkg::*;
#(
   parameter int unsigned STAB_TICKS = 8192
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_live,
   input  logic [3:0] wr_data,
   input  logic       main_tick_g,
   output logic [3:0] mode_q,
   output logic       wr_accept,
   output logic       illegal_q,
   output logic       stab_busy
);
   localparam int unsigned SW = (STAB_TICKS > 1) ? $clog2(STAB_TICKS) : 1;
   localparam logic [SW-1:0] STAB_LAST = SW'(STAB_TICKS - 1);

   logic          ok;
   logic [SW-1:0] stab_cnt;
   logic          restart_main;

   assign ok = step_allowed(mode_q, wr_data, stab_busy);
   assign wr_accept = wr_live && ok;
   assign restart_main = wr_accept && mode_q[MB_MAIN_HALT] &&
                         !wr_data[MB_MAIN_HALT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= MODE_AT_RESET;
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= wr_live && !ok;
         if (wr_accept) mode_q <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stab_busy <= 1'b0;
         stab_cnt  <= '0;
      end else if (restart_main) begin
         stab_busy <= 1'b1;
         stab_cnt  <= '0;
      end else if (mode_q[MB_MAIN_HALT]) begin
         stab_busy <= 1'b0;
      end else if (stab_busy && main_tick_g) begin
         if (stab_cnt == STAB_LAST) stab_busy <= 1'b0;
         else stab_cnt <= stab_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sysclk_tick_divider.sv
module sysclk_tick_divider #(
   parameter int unsigned DIV_FAST = 2,
   parameter int unsigned DIV_SLOW = 8,
   parameter int unsigned DIV_SUB  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   input  logic src_tick,
   input  logic src_sub,
   input  logic div_slow,
   output logic sys_tick
);
   localparam int unsigned MAXA = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
   localparam int unsigned MAXD = (MAXA > DIV_SUB) ? MAXA : DIV_SUB;
   localparam int unsigned CW = (MAXD > 1) ? $clog2(MAXD) : 1;

   generate
      if (MAXD == 1) begin : g_bypass
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else q <= run && !clear && src_tick;
         end
         assign sys_tick = q;
         logic unused_sel;
         assign unused_sel = src_sub ^ div_slow;
      end else begin : g_count
         localparam logic [CW-1:0] T_FAST = CW'(DIV_FAST - 1);
         localparam logic [CW-1:0] T_SLOW = CW'(DIV_SLOW - 1);
         localparam logic [CW-1:0] T_SUB = CW'(DIV_SUB - 1);
         logic [CW-1:0] cnt;
         logic [CW-1:0] term;
         logic          q;
         assign term = src_sub ? T_SUB : (div_slow ? T_SLOW : T_FAST);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
               q   <= 1'b0;
            end else begin
               q <= 1'b0;
               if (!run || clear) begin
                  cnt <= '0;
               end else if (src_tick) begin
                  if (cnt >= term) begin
                     cnt <= '0;
                     q   <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
         end
         assign sys_tick = q;
      end
   endgenerate

endmodule

// File: rtl/sysclk_power_seq.sv
module sysclk_power_seq
   import sysclk_pkg::*;
#(
   parameter int unsigned DELAY_TICKS = 8192
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req,
   input  logic       wait_req,
   input  logic       wake,
   input  logic       src_tick,
   output pwr_state_t state
);
   localparam int unsigned DW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
   localparam logic [DW-1:0] D_LAST = DW'((DELAY_TICKS > 0) ? DELAY_TICKS - 1 : 0);

   pwr_state_t st_q;
   logic       settle_end;
   logic [DW-1:0] dcnt;

   generate
      if (DELAY_TICKS == 0) begin : g_nodelay
         assign settle_end = 1'b1;
         assign dcnt = '0;
         logic unused_tick;
         assign unused_tick = src_tick;
      end else begin : g_delay
         logic [DW-1:0] c;
         always_ff @(posedge clk) begin
            if (!rst_n) c <= '0;
            else if (st_q != PS_SETTLE) c <= '0;
            else if (src_tick) c <= c + 1'b1;
         end
         assign dcnt = c;
         assign settle_end = src_tick && (c == D_LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= PS_RUN;
      end else begin
         unique case (st_q)
            PS_RUN: begin
               if (stop_req) st_q <= PS_STOP;
               else if (wait_req) st_q <= PS_WAIT;
            end
            PS_WAIT: if (wake) st_q <= PS_RUN;
            PS_STOP: if (wake) st_q <= PS_SETTLE;
            PS_SETTLE: if (settle_end) st_q <= PS_RUN;
            default: st_q <= PS_RUN;
         endcase
      end
   end

   logic unused_cnt;
   assign unused_cnt = ^dcnt;
   assign state = st_q;

endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
   import sysclk_pkg::*;
#(
   parameter int unsigned MAIN_DIV_FAST = 2,
   parameter int unsigned MAIN_DIV_SLOW = 8,
   parameter int unsigned SUB_DIV       = 2,
   parameter int unsigned STOP_DELAY    = 8192,
   parameter int unsigned MAIN_STAB     = 8192
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [3:0] wr_data,
   input  logic       main_tick,
   input  logic       sub_tick,
   input  logic       stop_req,
   input  logic       wait_req,
   input  logic       wake,
   output logic [3:0] mode,
   output logic       illegal_write,
   output logic       sys_tick,
   output logic       main_osc_en,
   output logic       sub_osc_en,
   output logic       periph_en
);
   generate
      if (MAIN_DIV_FAST < 1 || MAIN_DIV_SLOW < 1 || SUB_DIV < 1) begin : g_bad_div
         $error("sysclk_mode_ctrl: divide ratios must be at least 1");
      end
      if (MAIN_STAB < 1) begin : g_bad_stab
         $error("sysclk_mode_ctrl: MAIN_STAB must be at least 1");
      end
   endgenerate

   pwr_state_t pstate;
   logic [3:0] mode_q;
   logic       wr_live, wr_accept, stab_busy;
   logic       main_g, sub_g, src_g, running;

   assign running = (pstate == PS_RUN);
   assign wr_live = wr_en && running;

   assign main_osc_en = !mode_q[MB_MAIN_HALT] && (pstate != PS_STOP);
   assign sub_osc_en = mode_q[MB_SUB_ON] && (pstate != PS_STOP);
   assign periph_en = (pstate != PS_STOP);

   assign main_g = main_tick && main_osc_en;
   assign sub_g = sub_tick && sub_osc_en;
   assign src_g = mode_q[MB_SRC_SUB] ? sub_g : main_g;

   sysclk_mode_guard #(.STAB_TICKS(MAIN_STAB)) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_live    (wr_live),
      .wr_data    (wr_data),
      .main_tick_g(main_g),
      .mode_q     (mode_q),
      .wr_accept  (wr_accept),
      .illegal_q  (illegal_write),
      .stab_busy  (stab_busy)
   );

   sysclk_tick_divider #(
      .DIV_FAST(MAIN_DIV_FAST),
      .DIV_SLOW(MAIN_DIV_SLOW),
      .DIV_SUB (SUB_DIV)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (running),
      .clear   (wr_accept),
      .src_tick(src_g),
      .src_sub (mode_q[MB_SRC_SUB]),
      .div_slow(mode_q[MB_DIV_SLOW]),
      .sys_tick(sys_tick)
   );

   sysclk_power_seq #(.DELAY_TICKS(STOP_DELAY)) u_pwr (
      .clk     (clk),
      .rst_n   (rst_n),
      .stop_req(stop_req),
      .wait_req(wait_req),
      .wake    (wake),
      .src_tick(src_g),
      .state   (pstate)
   );

   assign mode = mode_q;

endmodule

// File: rtl/sysclk_mode_chk.sv
module sysclk_mode_chk
   import sysclk_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [3:0] mode,
   input logic       illegal_write,
   input logic       sys_tick,
   input logic       stab_busy,
   input pwr_state_t pstate
);
   // R5: the sub source is never selected while the sub-oscillator is off
   a_r5_src_needs_sub: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode[MB_SRC_SUB] && !mode[MB_SUB_ON]));

   // R5: the main oscillator is halted only while the sub source is selected
   a_r5_halt_needs_sub_src: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode[MB_MAIN_HALT] && !mode[MB_SRC_SUB]));

   // R6: at most one guarded bit changes per step
   a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      $countones((mode ^ $past(mode)) & GUARDED_BITS) <= 1);

   // R6: a rejected write leaves the register stable
   a_r6_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_write |-> $stable(mode));

   // R11: mode changes only after a write made while running
   a_r11_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode) |-> ($past(wr_en) && $past(pstate) == PS_RUN));

   // R9: the system tick follows only a running cycle
   a_r9_tick_only_running: assert property (@(posedge clk) disable iff (!rst_n)
      sys_tick |-> ($past(pstate) == PS_RUN));

   // R7: the source cannot return to main while stabilisation is pending
   a_r7_stab_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (stab_busy && mode[MB_SRC_SUB]) |=> mode[MB_SRC_SUB]);

endmodule

bind sysclk_mode_ctrl sysclk_mode_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .mode         (mode),
   .illegal_write(illegal_write),
   .sys_tick     (sys_tick),
   .stab_busy    (stab_busy),
   .pstate       (pstate)
);

// File: tb/sim_sysclk_mode_ctrl.sv
`timescale 1ns/1ps
module sim_sysclk_mode_ctrl;
   localparam int DF = 2;
   localparam int DS = 8;
   localparam int DB = 2;
   localparam int SD = 12;
   localparam int MS = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [3:0] wr_data = '0;
   logic main_tick = 1'b0, sub_tick = 1'b0;
   logic stop_req = 1'b0, wait_req = 1'b0, wake = 1'b0;
   logic [3:0] mode;
   logic illegal_write, sys_tick, main_osc_en, sub_osc_en, periph_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sysclk_mode_ctrl #(
      .MAIN_DIV_FAST(DF), .MAIN_DIV_SLOW(DS), .SUB_DIV(DB),
      .STOP_DELAY(SD), .MAIN_STAB(MS)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .main_tick(main_tick), .sub_tick(sub_tick), .stop_req(stop_req),
      .wait_req(wait_req), .wake(wake), .mode(mode),
      .illegal_write(illegal_write), .sys_tick(sys_tick),
      .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .periph_en(periph_en)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic ceq(input string req, input string what, input int act, input int exp);
      check(act == exp, req, what, act, exp);
   endtask

   function automatic bit valid_mode(input logic [3:0] m);
      return !(m[3] && !m[0]) && !(m[1] && !m[3]);
   endfunction

   function automatic bit ref_ok(input logic [3:0] c, input logic [3:0] n);
      logic [3:0] d;
      int k;
      d = (c ^ n) & 4'b1011;
      k = d[0] + d[1] + d[3];
      if (k == 0) return 1'b1;
      if (k > 1) return 1'b0;
      if (d[0]) return !c[3];
      if (d[1]) return c[3];
      return c[0] && !c[1];
   endfunction

   function automatic int div_of(input logic [3:0] m);
      return m[3] ? DB : (m[2] ? DS : DF);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0; main_tick = 1'b0; sub_tick = 1'b0;
      stop_req = 1'b0; wait_req = 1'b0; wake = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick_cycle(input bit m, input bit s, output bit st);
      main_tick = m; sub_tick = s;
      @(negedge clk);
      main_tick = 1'b0; sub_tick = 1'b0;
      st = sys_tick;
   endtask

   task automatic pulse_in(input int which);
      if (which == 0) stop_req = 1'b1;
      else if (which == 1) wait_req = 1'b1;
      else wake = 1'b1;
      @(negedge clk);
      stop_req = 1'b0; wait_req = 1'b0; wake = 1'b0;
   endtask

   task automatic goto(input logic [3:0] t);
      logic [3:0] m;
      do_reset();
      m = 4'b0100;
      m[2] = t[2];
      if (m != 4'b0100) wr(m);
      if (t[0]) begin m[0] = 1'b1; wr(m); end
      if (t[3]) begin m[3] = 1'b1; wr(m); end
      if (t[1]) begin m[1] = 1'b1; wr(m); end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      bit st;
      int cnt, first;
      logic [3:0] t;

      // R1 reset state
      do_reset();
      ceq("R1", "mode", mode, 4'b0100);
      ceq("R1", "main_osc_en", main_osc_en, 1);
      ceq("R1", "sub_osc_en", sub_osc_en, 0);
      ceq("R1", "periph_en", periph_en, 1);
      ceq("R1", "illegal_write", illegal_write, 0);
      ceq("R1", "sys_tick", sys_tick, 0);

      // R4 R5 R6: every write from every reachable mode
      for (int ti = 0; ti < 16; ti++) begin
         t = 4'(ti);
         if (!valid_mode(t)) continue;
         for (int di = 0; di < 16; di++) begin
            logic [3:0] d, dg;
            bit ok;
            string tag;
            d = 4'(di);
            goto(t);
            if (di == 0) begin
               ceq("R2", "main_osc_en", main_osc_en, !t[1]);
               ceq("R2", "sub_osc_en", sub_osc_en, t[0]);
            end
            wr(d);
            ok = ref_ok(t, d);
            dg = (t ^ d) & 4'b1011;
            tag = ((dg[0] + dg[1] + dg[3]) > 1) ? "R6" :
                  ((dg == 0) ? "R4" : "R5");
            ceq(tag, $sformatf("mode %b<-%b", t, d), mode, ok ? d : t);
            ceq(tag, $sformatf("flag %b<-%b", t, d), illegal_write, !ok);
            if (!ok) begin
               @(negedge clk);
               ceq("R6", "flag width", illegal_write, 0);
            end
         end
      end

      // R3 divide ratio per reachable mode, both oscillators ticking
      for (int ti = 0; ti < 16; ti++) begin
         t = 4'(ti);
         if (!valid_mode(t)) continue;
         goto(t);
         cnt = 0;
         for (int i = 0; i < 24; i++) begin
            tick_cycle(1'b1, 1'b1, st);
            cnt += st;
         end
         for (int i = 0; i < 2; i++) begin
            tick_cycle(1'b0, 1'b0, st);
            cnt += st;
         end
         ceq("R3", $sformatf("pulses in mode %b", t), cnt, 24 / div_of(t));
      end

      // R7 stabilisation window after restarting the main oscillator
      goto(4'b1111);
      wr(4'b1101);
      ceq("R7", "restart main", mode, 4'b1101);
      wr(4'b0101);
      ceq("R7", "early switch flag", illegal_write, 1);
      ceq("R7", "early switch mode", mode, 4'b1101);
      for (int i = 0; i < MS - 1; i++) tick_cycle(1'b1, 1'b0, st);
      wr(4'b0101);
      ceq("R7", "one tick short", mode, 4'b1101);
      tick_cycle(1'b1, 1'b0, st);
      wr(4'b0101);
      ceq("R7", "after window", mode, 4'b0101);
      ceq("R7", "after window flag", illegal_write, 0);

      // R9 wait mode
      do_reset();
      pulse_in(1);
      ceq("R9", "periph_en in wait", periph_en, 1);
      ceq("R9", "main_osc_en in wait", main_osc_en, 1);
      cnt = 0;
      for (int i = 0; i < 16; i++) begin tick_cycle(1'b1, 1'b0, st); cnt += st; end
      ceq("R9", "ticks in wait", cnt, 0);
      pulse_in(2);
      cnt = 0;
      for (int i = 0; i < 16; i++) begin tick_cycle(1'b1, 1'b0, st); cnt += st; end
      ceq("R9", "ticks after wake", cnt, 16 / DS);
      ceq("R9", "mode kept", mode, 4'b0100);

      // R8 R11 R10 stop from main source
      do_reset();
      pulse_in(0);
      ceq("R8", "main_osc_en in stop", main_osc_en, 0);
      ceq("R8", "sub_osc_en in stop", sub_osc_en, 0);
      ceq("R8", "periph_en in stop", periph_en, 0);
      cnt = 0;
      for (int i = 0; i < 30; i++) begin tick_cycle(1'b1, 1'b1, st); cnt += st; end
      ceq("R8", "ticks in stop", cnt, 0);
      wr(4'b0000);
      ceq("R11", "mode after write in stop", mode, 4'b0100);
      ceq("R11", "flag after write in stop", illegal_write, 0);
      pulse_in(2);
      first = 0;
      for (int i = 1; i <= 60; i++) begin
         tick_cycle(1'b1, 1'b0, st);
         if (st && first == 0) first = i;
      end
      ceq("R10", "main source release ticks", first, SD + DS);
      ceq("R8", "mode after stop", mode, 4'b0100);

      // R10 stop from sub source: main ticks must not end the delay
      goto(4'b1101);
      pulse_in(0);
      pulse_in(2);
      cnt = 0;
      for (int i = 0; i < 40; i++) begin tick_cycle(1'b1, 1'b0, st); cnt += st; end
      ceq("R10", "main ticks during sub settle", cnt, 0);
      first = 0;
      for (int i = 1; i <= 40; i++) begin
         tick_cycle(1'b0, 1'b1, st);
         if (st && first == 0) first = i;
      end
      ceq("R10", "sub source release ticks", first, SD + DB);

      // R8 stop wins over wait
      do_reset();
      stop_req = 1'b1; wait_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0; wait_req = 1'b0;
      ceq("R8", "stop priority periph_en", periph_en, 0);
      ceq("R8", "stop priority main_osc_en", main_osc_en, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule